// File: doc/BRIEF.md
# Timeslot to Channel Mapper

This block sits between a framed PCM highway of byte-wide timeslots and a set of logical channels. Every clock carries one timeslot. A per-timeslot assignment table gives each direction its own channel number, its own inhibit flag and its own 8-bit fill mask. A timeslot can therefore feed one channel in one direction and a different channel in the other, and it can carry fewer than eight payload bits.

On the transmit side the block names the channel whose byte it needs. It then merges that byte with fill ones under the mask. On the receive side it extracts the bits the mask selects, packs them toward bit 0, and hands them to the selected channel with a bit count.

Software stages new assignment words through a word-wide load port into a shadow table. A reload command commits the shadow table. While the highway is framed, the commit waits for the next frame boundary so that a frame never mixes two tables.

The sequencer has three named states:
- **ST_HUNT**: no frame sync has been seen yet. The transition ST_HUNT→ST_RUN is taken on `fsync`.
- **ST_RUN**: framed, and no commit is waiting. The transition ST_RUN→ST_ARMED is taken on `reload` away from a boundary. A `reload` on a boundary commits at once and stays in ST_RUN.
- **ST_ARMED**: framed, with a commit waiting. The transition ST_ARMED→ST_RUN is taken at the next boundary, where the table swaps.

A boundary is the clock edge that makes the slot 0. That edge is either `fsync` or the wrap from the last slot.

Top module: `tsmap_top`

## Requirements
- R1: After reset the block is unframed: `framed`=0, `slot_num`=0, `slot_idle`=1, `tx_line_byte`=8'hFF, `tx_ch_req`=0 and `rx_ch_valid`=0. Both tables hold every slot with both directions inhibited.
- R2: An edge with `fsync`=1 makes `slot_num` 0 in the following cycle and sets `framed`. While framed, `slot_num` rises by one per clock and wraps from 31 to 0 without `fsync`. An `fsync` in mid-frame restarts the count at 0.
- R3: A load-port write at byte address 12+4*n (n from 0 to 31) stores the word as shadow entry n. A write to any other address, including an unaligned one, to 8 or to 140, changes no entry.
- R4: The assignment word layout is as follows. Bit 29 inhibits transmit, bits 28:24 are the transmit channel and bits 23:16 are the transmit mask. Bit 13 inhibits receive, bits 12:8 are the receive channel and bits 7:0 are the receive mask. While framed, `tx_ch_sel` and `rx_ch_sel` show the channels of the current slot whatever the inhibit bits are; while unframed they are 0.
- R5: A `reload` while unframed copies the shadow table into the active table at that edge. Shadow writes have no effect on the outputs until a `reload` commits them.
- R6: A `reload` while framed commits at the next boundary, so every slot up to the last one before that boundary uses the old table. A `reload` in the cycle of slot 31, or together with `fsync`, commits for the slot 0 that follows.
- R7: In a framed slot whose transmit direction is not inhibited, `tx_ch_req`=1 and `tx_line_byte` = (`tx_ch_byte` AND mask) OR (NOT mask).
- R8: While unframed, or in a slot whose transmit direction is inhibited, `tx_line_byte`=8'hFF and `tx_ch_req`=0.
- R9: In a framed slot whose receive direction is not inhibited and whose mask is nonzero, `rx_ch_valid`=1. The `rx_line_byte` bits at mask-one positions appear in `rx_ch_bits` packed from bit 0 upward in rising position order, with zeros above them. `rx_ch_count` equals the number of mask ones.
- R10: While unframed, in a slot whose receive direction is inhibited, or in a slot with receive mask 0, `rx_ch_valid`=0 and `rx_ch_bits`=0 and `rx_ch_count`=0.
- R11: `slot_idle`=1 while unframed or when both inhibit bits of the current slot are set, and 0 otherwise.
- R12: A shadow write in the same cycle as a `reload` that commits on that very edge is not part of that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timeslot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load-port write strobe |
| cfg_addr | input | 10 | Load-port byte address |
| cfg_wdata | input | 32 | Assignment word |
| reload | input | 1 | Commit shadow table to active table |
| fsync | input | 1 | Frame sync; next cycle is slot 0 |
| tx_ch_byte | input | 8 | Byte supplied by the selected transmit channel |
| tx_ch_sel | output | 5 | Transmit channel of the current slot |
| tx_ch_req | output | 1 | Transmit channel byte is consumed this slot |
| tx_line_byte | output | 8 | Byte driven onto the highway |
| rx_line_byte | input | 8 | Byte received from the highway |
| rx_ch_sel | output | 5 | Receive channel of the current slot |
| rx_ch_valid | output | 1 | Receive bits are delivered this slot |
| rx_ch_bits | output | 8 | Masked receive bits, packed from bit 0 |
| rx_ch_count | output | 4 | Number of valid receive bits |
| slot_num | output | 5 | Current timeslot index |
| slot_idle | output | 1 | Slot unused in both directions |
| framed | output | 1 | Frame alignment established |

## Verification
The bench aims at the commit timing first. A reload early in a frame, a reload on slot 31, and a reload followed by a mid-frame `fsync` each catch a design that swaps at once or one frame late: slots before the boundary would show the new channels, or slot 0 would keep the old ones. A write issued with a committing reload catches a design that forwards the write into the commit. Writes to addresses 8, 140 and an unaligned one catch loose decoding, which would alias them onto entry 0 or entry 31. Masks that are sparse, full or zero, combined with one-way and two-way inhibits, catch packing errors, inverted fill polarity and a valid flag raised for an empty mask.

// File: rtl/tsmap_pkg.sv
package tsmap_pkg;

    localparam int CH_W   = 5;
    localparam int MASK_W = 8;
    localparam int CNT_W  = $clog2(MASK_W + 1);

    typedef struct packed {
        logic              tx_inh;
        logic [CH_W-1:0]   tx_ch;
        logic [MASK_W-1:0] tx_mask;
        logic              rx_inh;
        logic [CH_W-1:0]   rx_ch;
        logic [MASK_W-1:0] rx_mask;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } seq_state_t;

    localparam slot_cfg_t SLOT_OFF = '{
        tx_inh: 1'b1, tx_ch: '0, tx_mask: '0,
        rx_inh: 1'b1, rx_ch: '0, rx_mask: '0
    };

    function automatic slot_cfg_t unpack_word(input logic [31:0] w);
        slot_cfg_t c;
        c.tx_inh  = w[29];
        c.tx_ch   = w[28:24];
        c.tx_mask = w[23:16];
        c.rx_inh  = w[13];
        c.rx_ch   = w[12:8];
        c.rx_mask = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/tsmap_seq.sv
module tsmap_seq #(
    parameter int NUM_SLOTS = 32,
    localparam int TS_W = $clog2(NUM_SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fsync,
    input  logic            reload,
    output logic [TS_W-1:0] slot_q,
    output logic            framed,
    output logic            swap
);
    import tsmap_pkg::*;

    localparam logic [TS_W-1:0] LAST_SLOT = TS_W'(NUM_SLOTS - 1);

    seq_state_t state_q, state_d;
    logic       boundary;

    assign boundary = fsync || (slot_q == LAST_SLOT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (fsync)                 state_d = ST_RUN;
            ST_RUN:   if (reload && !boundary)   state_d = ST_ARMED;
            ST_ARMED: if (boundary)              state_d = ST_RUN;
            default:                             state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        swap   = 1'b0;
        framed = 1'b0;
        unique case (state_q)
            ST_HUNT:  swap = reload;
            ST_RUN:   begin framed = 1'b1; swap = reload && boundary; end
            ST_ARMED: begin framed = 1'b1; swap = boundary; end
            default:  swap = 1'b0;
        endcase
    end

    // slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      slot_q <= '0;
        else if (fsync)                  slot_q <= '0;
        else if (framed) begin
            if (slot_q == LAST_SLOT)     slot_q <= '0;
            else                         slot_q <= slot_q + 1'b1;
        end
    end

    p_fsync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (slot_q == '0 && framed));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(framed) && !$past(fsync)) |->
        (slot_q == (($past(slot_q) == LAST_SLOT) ? '0 : $past(slot_q) + 1'b1)));

    p_swap_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && framed) |=> (slot_q == '0));

    p_framed_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        framed |=> framed);

endmodule

// File: rtl/tsmap_table.sv
module tsmap_table #(
    parameter int NUM_SLOTS = 32,
    parameter int AW        = 10,
    parameter int BASE_ADDR = 12,
    localparam int TS_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 swap,
    input  logic [TS_W-1:0]      slot,
    output tsmap_pkg::slot_cfg_t cur_cfg
);
    import tsmap_pkg::*;

    localparam logic [AW-1:0] BASE_A = AW'(BASE_ADDR);
    localparam logic [AW-1:0] SPAN_A = AW'(NUM_SLOTS * 4);

    slot_cfg_t       shadow_q [NUM_SLOTS];
    slot_cfg_t       active_q [NUM_SLOTS];
    logic [AW-1:0]   rel;
    logic            hit;
    logic [TS_W-1:0] idx;
    slot_cfg_t       new_cfg;

    assign rel     = cfg_addr - BASE_A;
    assign hit     = cfg_we && (cfg_addr >= BASE_A) && (rel < SPAN_A) && (rel[1:0] == 2'b00);
    assign idx     = rel[TS_W+1:2];
    assign new_cfg = unpack_word(cfg_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                shadow_q[i] <= SLOT_OFF;
                active_q[i] <= SLOT_OFF;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (swap)                          active_q[i] <= shadow_q[i];
                if (hit && idx == TS_W'(i))        shadow_q[i] <= new_cfg;
            end
        end
    end

    assign cur_cfg = active_q[slot];

    p_hold_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(swap) && $past(slot) == slot) |-> $stable(cur_cfg));

endmodule

// File: rtl/tsmap_tx.sv
module tsmap_tx (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 framed,
    input  tsmap_pkg::slot_cfg_t cfg,
    input  logic [7:0]           tx_ch_byte,
    output logic [4:0]           tx_ch_sel,
    output logic                 tx_ch_req,
    output logic [7:0]           tx_line_byte
);
    import tsmap_pkg::*;

    logic live;
    assign live      = framed && !cfg.tx_inh;
    assign tx_ch_req = live;
    assign tx_ch_sel = framed ? cfg.tx_ch : '0;

    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        assign tx_line_byte[b] = live ? (cfg.tx_mask[b] ? tx_ch_byte[b] : 1'b1) : 1'b1;
    end

    p_fill_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_line_byte | cfg.tx_mask) == 8'hFF);

    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ch_req |-> (tx_line_byte == 8'hFF));

endmodule

// File: rtl/tsmap_rx.sv
module tsmap_rx (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 framed,
    input  tsmap_pkg::slot_cfg_t cfg,
    input  logic [7:0]           rx_line_byte,
    output logic [4:0]           rx_ch_sel,
    output logic                 rx_ch_valid,
    output logic [7:0]           rx_ch_bits,
    output logic [3:0]           rx_ch_count
);
    import tsmap_pkg::*;

    logic [CNT_W-1:0] prefix [MASK_W+1];
    logic [MASK_W-1:0] packed_bits;

    assign prefix[0] = '0;
    for (genvar b = 0; b < MASK_W; b++) begin : g_prefix
        assign prefix[b+1] = prefix[b] + CNT_W'(cfg.rx_mask[b]);
    end

    always_comb begin
        packed_bits = '0;
        for (int b = 0; b < MASK_W; b++) begin
            if (cfg.rx_mask[b]) packed_bits[prefix[b][2:0]] = rx_line_byte[b];
        end
    end

    assign rx_ch_valid = framed && !cfg.rx_inh && (cfg.rx_mask != '0);
    assign rx_ch_sel   = framed ? cfg.rx_ch : '0;
    assign rx_ch_bits  = rx_ch_valid ? packed_bits : '0;
    assign rx_ch_count = rx_ch_valid ? prefix[MASK_W] : '0;

    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ch_valid |-> (32'(rx_ch_count) == $countones(cfg.rx_mask)));

    p_pack_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ch_valid |-> ((rx_ch_bits >> rx_ch_count) == 8'h00));

    p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ch_valid |-> (rx_ch_bits == 8'h00 && rx_ch_count == 4'd0));

endmodule

// File: rtl/tsmap_top.sv
module tsmap_top #(
    parameter int NUM_SLOTS = 32,
    parameter int AW        = 10,
    parameter int BASE_ADDR = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          reload,
    input  logic          fsync,
    input  logic [7:0]    tx_ch_byte,
    output logic [4:0]    tx_ch_sel,
    output logic          tx_ch_req,
    output logic [7:0]    tx_line_byte,
    input  logic [7:0]    rx_line_byte,
    output logic [4:0]    rx_ch_sel,
    output logic          rx_ch_valid,
    output logic [7:0]    rx_ch_bits,
    output logic [3:0]    rx_ch_count,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_num,
    output logic          slot_idle,
    output logic          framed
);
    import tsmap_pkg::*;

    localparam int TS_W = $clog2(NUM_SLOTS);

    logic            swap;
    logic [TS_W-1:0] slot_q;
    slot_cfg_t       cur_cfg;

    tsmap_seq #(.NUM_SLOTS(NUM_SLOTS)) i_seq (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .reload(reload),
        .slot_q(slot_q), .framed(framed), .swap(swap)
    );

    tsmap_table #(.NUM_SLOTS(NUM_SLOTS), .AW(AW), .BASE_ADDR(BASE_ADDR)) i_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .swap(swap), .slot(slot_q), .cur_cfg(cur_cfg)
    );

    tsmap_tx i_tx (
        .clk(clk), .rst_n(rst_n), .framed(framed), .cfg(cur_cfg),
        .tx_ch_byte(tx_ch_byte), .tx_ch_sel(tx_ch_sel),
        .tx_ch_req(tx_ch_req), .tx_line_byte(tx_line_byte)
    );

    tsmap_rx i_rx (
        .clk(clk), .rst_n(rst_n), .framed(framed), .cfg(cur_cfg),
        .rx_line_byte(rx_line_byte), .rx_ch_sel(rx_ch_sel),
        .rx_ch_valid(rx_ch_valid), .rx_ch_bits(rx_ch_bits),
        .rx_ch_count(rx_ch_count)
    );

    assign slot_num  = slot_q;
    assign slot_idle = !framed || (cur_cfg.tx_inh && cur_cfg.rx_inh);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idle |-> (!tx_ch_req && !rx_ch_valid));

endmodule

// File: tb/test_tsmap_top.sv
module test_tsmap_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [9:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        reload, fsync;
    logic [7:0]  tx_ch_byte, rx_line_byte;
    logic [4:0]  tx_ch_sel, rx_ch_sel, slot_num;
    logic        tx_ch_req, rx_ch_valid, slot_idle, framed;
    logic [7:0]  tx_line_byte, rx_ch_bits;
    logic [3:0]  rx_ch_count;

    always #2 clk = ~clk;

    tsmap_top i_tsmap_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .reload(reload), .fsync(fsync),
        .tx_ch_byte(tx_ch_byte), .tx_ch_sel(tx_ch_sel), .tx_ch_req(tx_ch_req),
        .tx_line_byte(tx_line_byte), .rx_line_byte(rx_line_byte),
        .rx_ch_sel(rx_ch_sel), .rx_ch_valid(rx_ch_valid), .rx_ch_bits(rx_ch_bits),
        .rx_ch_count(rx_ch_count), .slot_num(slot_num), .slot_idle(slot_idle),
        .framed(framed)
    );

    int    checks = 0, fails = 0;
    string phase  = "R1";

    // reference model state
    logic [31:0] sh [32];
    logic [31:0] ac [32];
    bit          mfr, marm;
    int          msl;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s, phase %s) actual=%h expected=%h", req, what, phase, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] w;
        logic [7:0]  m, etx, ebits;
        bit          q[$];
        bit          ev;
        w = ac[msl];
        chk("R2", "framed", 32'(framed), 32'(mfr));
        chk("R2", "slot_num", 32'(slot_num), mfr ? msl : 0);
        chk("R11", "slot_idle", 32'(slot_idle), 32'(!mfr || (w[29] && w[13])));
        chk("R4", "tx_ch_sel", 32'(tx_ch_sel), mfr ? 32'(w[28:24]) : 0);
        chk("R4", "rx_ch_sel", 32'(rx_ch_sel), mfr ? 32'(w[12:8]) : 0);
        m = w[23:16];
        if (!mfr || w[29]) begin
            chk("R8", "tx_line_byte", 32'(tx_line_byte), 32'hFF);
            chk("R8", "tx_ch_req", 32'(tx_ch_req), 0);
        end else begin
            etx = (tx_ch_byte & m) | ~m;
            chk("R7", "tx_line_byte", 32'(tx_line_byte), 32'(etx));
            chk("R7", "tx_ch_req", 32'(tx_ch_req), 1);
        end
        m  = w[7:0];
        ev = mfr && !w[13] && (m != 0);
        ebits = 8'h00;
        if (ev) begin
            for (int i = 0; i < 8; i++) if (m[i]) q.push_back(rx_line_byte[i]);
            for (int j = 0; j < q.size(); j++) ebits[j] = q[j];
            chk("R9", "rx_ch_valid", 32'(rx_ch_valid), 1);
            chk("R9", "rx_ch_bits", 32'(rx_ch_bits), 32'(ebits));
            chk("R9", "rx_ch_count", 32'(rx_ch_count), q.size());
        end else begin
            chk("R10", "rx_ch_valid", 32'(rx_ch_valid), 0);
            chk("R10", "rx_ch_bits", 32'(rx_ch_bits), 0);
            chk("R10", "rx_ch_count", 32'(rx_ch_count), 0);
        end
    endtask

    task automatic cyc(bit fs, bit rl, bit we, logic [9:0] a, logic [31:0] d);
        bit bnd, sw, narm;
        @(negedge clk);
        fsync = fs; reload = rl; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        tx_ch_byte = 8'($urandom); rx_line_byte = 8'($urandom);
        #1 compare();
        @(posedge clk);
        bnd  = mfr && (fs || msl == 31);
        sw   = (!mfr && rl) || (mfr && (marm || rl) && bnd);
        narm = mfr && !bnd && (marm || rl);
        if (sw) for (int i = 0; i < 32; i++) ac[i] = sh[i];
        if (we && a >= 12 && a < 140 && a[1:0] == 2'b00) sh[(a - 12) / 4] = d;
        if (fs) msl = 0;
        else if (mfr) msl = (msl + 1) % 32;
        marm = narm;
        mfr  = mfr || fs;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 10'd0, 32'd0);
    endtask

    task automatic wait_slot(int s);
        while (msl != s) cyc(0, 0, 0, 10'd0, 32'd0);
    endtask

    function automatic logic [31:0] gen(int n);
        logic [31:0] w;
        w = $urandom;
        w[31:30] = 2'b00; w[15:14] = 2'b00;
        w[29] = (n % 7 == 0) || (n % 11 == 0);
        w[13] = (n % 5 == 0) || (n % 11 == 0);
        if (n % 6 == 1) w[7:0] = 8'h00;
        if (n % 4 == 2) begin w[23:16] = 8'hFF; w[7:0] = 8'hFF; end
        if (n % 9 == 3) begin w[23:16] = 8'h81; w[7:0] = 8'h5A; end
        return w;
    endfunction

    task automatic load_all();
        for (int n = 0; n < 32; n++) cyc(0, 0, 1, 10'(12 + 4 * n), gen(n));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fsync = 0; reload = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        tx_ch_byte = 0; rx_line_byte = 0;
        for (int i = 0; i < 32; i++) begin sh[i] = 32'h2000_2000; ac[i] = 32'h2000_2000; end
        mfr = 0; marm = 0; msl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        phase = "R1";  idle(4);
        phase = "R3";  load_all();
        cyc(0, 0, 1, 10'd8,   32'h1F1F_1F1F);
        cyc(0, 0, 1, 10'd140, 32'h1E0F_1E0F);
        cyc(0, 0, 1, 10'd14,  32'h0AFF_0AFF);
        cyc(0, 0, 1, 10'd1023, 32'h0155_0155);
        phase = "R5";  idle(2); cyc(0, 1, 0, 10'd0, 32'd0); idle(2);
        phase = "R2";  cyc(1, 0, 0, 10'd0, 32'd0); idle(70);
        phase = "R6";  load_all();
        wait_slot(10); cyc(0, 1, 0, 10'd0, 32'd0); idle(40);
        load_all();
        wait_slot(31); cyc(0, 1, 0, 10'd0, 32'd0); idle(6);
        load_all();
        wait_slot(5); cyc(0, 1, 0, 10'd0, 32'd0);
        wait_slot(12); cyc(1, 0, 0, 10'd0, 32'd0); idle(40);
        phase = "R12";
        wait_slot(31); cyc(0, 1, 1, 10'd12, 32'h0342_0924); idle(4);
        wait_slot(20); cyc(0, 1, 0, 10'd0, 32'd0); idle(20);
        phase = "R2";  wait_slot(17); cyc(1, 0, 0, 10'd0, 32'd0); idle(40);
        phase = "R4";  idle(32);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule